// File: doc/BRIEF.md
# Capture-and-Readout Sequencer

This block is the host-side control sequencer for a sampling bridge. It steps through seven states. First it captures a burst of samples into external memory. It then waits for the host to ask for the data and streams that data from memory into a readout FIFO. Finally it counts the host's fetches until the requested number of samples has been consumed. The host controls the flow through a small register file on a plain 32-bit write/read bus. It learns about progress from a status word and from one interrupt level. That level is the OR of the pending event causes that the host has enabled.

The memory controller, the FIFOs and the host bus timing lie outside this block. They appear only as done pulses, a FIFO fill level and a one-cycle fetch strobe. No data words pass through this block, so it has no valid/ready stream. Every pin is a plain control or status level. The register read path is combinational from `reg_addr`.

Top module: `cap_readout_seq`

## Requirements
- R1: After reset the state is Idle (code 0), every register reads 0, and `irq`, `cap_en` and `m2f_en` are low.
- R2: Idle is left only in a cycle where three conditions hold together: `mem_init_done` is high, soft-start (control bit 0) is 1, and a synchronised rising edge of `hard_cap` is seen. The block then enters Capture (code 1) and holds `cap_en` high for as long as it stays there.
- R3: `hard_cap` is synchronised by two flops and then edge-detected. If it rises before clock edge k, the state reads Capture after edge k+2 and not earlier.
- R4: In Capture, a `cap_done` pulse moves the block to Memory-Transfer (code 2) and drops `cap_en`. If `cap_forced` is high with it, status bit 4 is set and cause bit 0 is set. Cause bit 0 always reaches `irq`, whatever the mask holds.
- R5: In Memory-Transfer, a `mem_done` pulse sets cause bit 1 and moves the block to Read-Request (code 3).
- R6: In Read-Request, once control bit 1 (read request) is 1, the block loads `cap_count` into the actual-count register (address 5). It then moves to FIFO-Ready (code 4), raises `m2f_en` and clears control bit 1.
- R7: In FIFO-Ready, the block stays while `fifo_level` is below 64. On the first cycle that `fifo_level` is 64 or more, it sets status bit 3 (data ready) and cause bit 2, and moves to Read-Sample-Data (code 5).
- R8: Read-Sample-Data moves to Complete (code 6) only when control bit 2 (acknowledge) is 1 and the memory-to-FIFO transfer has finished. An `m2f_done` pulse that arrives before the acknowledge is remembered. `m2f_en` drops when the block leaves this state, and control bit 2 is cleared.
- R9: The block counts `host_pop` strobes from FIFO-Ready onwards. In Complete, once that count reaches the target (address 4), it sets cause bit 3, clears data ready and returns to Idle. A target of 0 returns to Idle at once.
- R10: `irq` equals the OR of cause bits ANDed with the mask (address 2, bit i enables cause i). Writing 1 to a bit of the cause register (address 3) clears that bit. When a write clears a cause bit in the same cycle that its event sets it, the bit stays set.
- R11: Register map by word address: 0 control (bit 0 soft-start, bit 1 read request, bit 2 acknowledge), 1 status (bits 2:0 state code, bit 3 data ready, bit 4 forced stop), 2 mask, 3 cause, 4 target count, 5 actual count. Status is recomputed every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mem_init_done | input | 1 | External memory is initialised |
| hard_cap | input | 1 | Asynchronous hardware capture trigger |
| cap_done | input | 1 | Capture finished (pulse) |
| cap_forced | input | 1 | Qualifies `cap_done` as a forced stop |
| cap_count | input | 32 | Number of samples actually stored |
| mem_done | input | 1 | Capture data is written to memory (pulse) |
| m2f_done | input | 1 | Memory-to-FIFO transfer finished (pulse) |
| fifo_level | input | 8 | Readout FIFO fill level in samples |
| host_pop | input | 1 | Host fetched one sample |
| cap_en | output | 1 | Capture enable |
| m2f_en | output | 1 | Memory-to-FIFO transfer enable |
| irq | output | 1 | Interrupt level |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a host write that clears a cause bit and the hardware event that sets the same bit. The bench issues a write-1-to-clear of cause bit 1 in the very cycle `mem_done` arrives, and it expects the bit to read back as 1. The second pair is the transfer-done pulse and the acknowledge. The bench sends `m2f_done` both before and after the acknowledge write, and it expects Complete to be entered exactly one cycle after the later of the two.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CAPT  = 3'd1,
    ST_MEMX  = 3'd2,
    ST_RREQ  = 3'd3,
    ST_FRDY  = 3'd4,
    ST_RDAT  = 3'd5,
    ST_DONE  = 3'd6
  } cr_state_e;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_STAT   = 3'd1;
  localparam logic [2:0] A_MASK   = 3'd2;
  localparam logic [2:0] A_CAUSE  = 3'd3;
  localparam logic [2:0] A_TARGET = 3'd4;
  localparam logic [2:0] A_ACTUAL = 3'd5;

  localparam int N_CAUSE = 4;
endpackage

// File: rtl/cr_edge_sync.sv
module cr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cr_irq.sv
module cr_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_bits,
  input  logic [N-1:0] enable,
  output logic [N-1:0] cause_o,
  output logic         irq_o
);
  logic [N-1:0] cause_q;
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= (cause_q & ~clr_eff) | set_i;
  end

  assign cause_o = cause_q;
  assign irq_o   = |(cause_q & enable);

  // R10
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(cause_q) & ~cause_q)) |-> $past(clr_wr));
endmodule

// File: rtl/cap_readout_seq.sv
module cap_readout_seq
  import cr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LVL_W       = 8,
  parameter int READY_LEVEL = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              mem_init_done,
  input  logic              hard_cap,
  input  logic              cap_done,
  input  logic              cap_forced,
  input  logic [DATA_W-1:0] cap_count,
  input  logic              mem_done,
  input  logic              m2f_done,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              host_pop,
  output logic              cap_en,
  output logic              m2f_en,
  output logic              irq
);
  localparam logic [LVL_W-1:0] READY_LVL = LVL_W'(READY_LEVEL);

  cr_state_e           state_q, nxt;
  logic                soft_q, rreq_q, rack_q;
  logic [N_CAUSE-1:0]  mask_q, cause, set_ev;
  logic [DATA_W-1:0]   target_q, actual_q, fetched_q;
  logic                dready_q, forced_q, m2f_seen_q;
  logic                hard_rise, start_go, fetched_all, m2f_fin;
  logic                wr_ctrl, wr_mask, wr_cause, wr_target;

  cr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(hard_cap), .rise_o(hard_rise)
  );

  assign wr_ctrl   = reg_wr && reg_addr == A_CTRL;
  assign wr_mask   = reg_wr && reg_addr == A_MASK;
  assign wr_cause  = reg_wr && reg_addr == A_CAUSE;
  assign wr_target = reg_wr && reg_addr == A_TARGET;

  assign start_go    = mem_init_done && soft_q && hard_rise;
  assign fetched_all = fetched_q >= target_q;
  assign m2f_fin     = m2f_done || m2f_seen_q;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_IDLE: if (start_go)                      nxt = ST_CAPT;
      ST_CAPT: if (cap_done)                      nxt = ST_MEMX;
      ST_MEMX: if (mem_done)                      nxt = ST_RREQ;
      ST_RREQ: if (rreq_q)                        nxt = ST_FRDY;
      ST_FRDY: if (fifo_level >= READY_LVL)       nxt = ST_RDAT;
      ST_RDAT: if (rack_q && m2f_fin)             nxt = ST_DONE;
      ST_DONE: if (fetched_all)                   nxt = ST_IDLE;
      default:                                    nxt = ST_IDLE;
    endcase
  end

  assign set_ev[0] = state_q == ST_CAPT && cap_done && cap_forced;
  assign set_ev[1] = state_q == ST_MEMX && mem_done;
  assign set_ev[2] = state_q == ST_FRDY && nxt == ST_RDAT;
  assign set_ev[3] = state_q == ST_DONE && fetched_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      soft_q     <= 1'b0;
      rreq_q     <= 1'b0;
      rack_q     <= 1'b0;
      mask_q     <= '0;
      target_q   <= '0;
      actual_q   <= '0;
      fetched_q  <= '0;
      dready_q   <= 1'b0;
      forced_q   <= 1'b0;
      m2f_seen_q <= 1'b0;
    end else begin
      state_q <= nxt;
      // requests are consumed by the FSM; a same-cycle write takes over
      if (state_q == ST_RREQ && nxt == ST_FRDY) rreq_q <= 1'b0;
      if (state_q == ST_RDAT && nxt == ST_DONE) rack_q <= 1'b0;
      if (wr_ctrl) begin
        soft_q <= reg_wdata[0];
        rreq_q <= reg_wdata[1];
        rack_q <= reg_wdata[2];
      end
      if (wr_mask)   mask_q   <= reg_wdata[N_CAUSE-1:0];
      if (wr_target) target_q <= reg_wdata;
      if (state_q == ST_RREQ && rreq_q) actual_q <= cap_count;

      if (state_q == ST_IDLE)
        fetched_q <= '0;
      else if (host_pop && (state_q == ST_FRDY || state_q == ST_RDAT || state_q == ST_DONE)
               && fetched_q != '1)
        fetched_q <= fetched_q + 1'b1;

      if (set_ev[2])                             dready_q <= 1'b1;
      else if (state_q == ST_DONE && fetched_all) dready_q <= 1'b0;

      if (set_ev[0])                              forced_q <= 1'b1;
      else if (state_q == ST_IDLE && start_go)    forced_q <= 1'b0;

      if (state_q == ST_DONE)                     m2f_seen_q <= 1'b0;
      else if (m2f_en && m2f_done)                m2f_seen_q <= 1'b1;
    end
  end

  cr_irq #(.N(N_CAUSE)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(set_ev),
    .clr_wr(wr_cause), .clr_bits(reg_wdata[N_CAUSE-1:0]),
    .enable(mask_q | N_CAUSE'(1)),
    .cause_o(cause), .irq_o(irq)
  );

  assign cap_en = state_q == ST_CAPT;
  assign m2f_en = state_q == ST_FRDY || state_q == ST_RDAT;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL:   reg_rdata[2:0] = {rack_q, rreq_q, soft_q};
      A_STAT:   reg_rdata[4:0] = {forced_q, dready_q, state_q};
      A_MASK:   reg_rdata[N_CAUSE-1:0] = mask_q;
      A_CAUSE:  reg_rdata[N_CAUSE-1:0] = cause;
      A_TARGET: reg_rdata = target_q;
      A_ACTUAL: reg_rdata = actual_q;
      default:  reg_rdata = '0;
    endcase
  end

  // R2
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_en) |-> $past(soft_q && mem_init_done));
  // R4
  cap_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_en) |-> $past(cap_done));
  // R7
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dready_q) |-> $past(fifo_level >= READY_LVL));
  // R8
  xfer_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(m2f_en) |-> $past(rack_q));
  // R9
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q == ST_DONE) && state_q == ST_IDLE) |-> $past(fetched_q >= target_q));
endmodule

// File: tb/cap_readout_seq_test.sv
module cap_readout_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_init_done = 1'b0, hard_cap = 1'b0, cap_done = 1'b0, cap_forced = 1'b0;
  logic [31:0] cap_count = '0;
  logic        mem_done = 1'b0, m2f_done = 1'b0, host_pop = 1'b0;
  logic [7:0]  fifo_level = '0;
  logic        cap_en, m2f_en, irq;
  int          errors = 0, checks = 0;
  bit          finished = 1'b0;

  cap_readout_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_init_done(mem_init_done),
    .hard_cap(hard_cap), .cap_done(cap_done), .cap_forced(cap_forced),
    .cap_count(cap_count), .mem_done(mem_done), .m2f_done(m2f_done),
    .fifo_level(fifo_level), .host_pop(host_pop), .cap_en(cap_en),
    .m2f_en(m2f_en), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic chk_state(input string req, input logic [2:0] exp);
    logic [31:0] d;
    rd(3'd1, d);
    chk(req, {29'd0, d[2:0]}, {29'd0, exp});
  endtask

  task automatic run_flow(input int tgt, input bit forced, input logic [3:0] m, input bit early);
    logic [31:0] d;
    wr(3'd2, {28'd0, m});
    wr(3'd4, tgt);
    wr(3'd0, 32'd1);
    rd(3'd2, d); chk("R11 mask readback", d, {28'd0, m});
    rd(3'd4, d); chk("R11 target readback", d, tgt);
    hard_cap = 1'b1;
    tick(2);
    chk_state("R3 no start before sync", 3'd0);
    tick();
    chk_state("R3 start after sync", 3'd1);
    chk("R2 cap_en in capture", cap_en, 1);
    hard_cap = 1'b0;
    cap_count = 32'd100 + tgt;
    cap_done = 1'b1; cap_forced = forced;
    tick();
    cap_done = 1'b0; cap_forced = 1'b0;
    chk_state("R4 to memory transfer", 3'd2);
    chk("R4 cap_en drops", cap_en, 0);
    rd(3'd1, d); chk("R4 forced status bit", d[4], forced);
    chk("R4 forced irq unmasked", irq, forced);
    wr(3'd3, 32'hF);
    chk("R10 w1c clears irq", irq, 0);
    // same-cycle clear and set of cause bit 1
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'd2; mem_done = 1'b1;
    tick();
    reg_wr = 1'b0; mem_done = 1'b0;
    chk_state("R5 to read request", 3'd3);
    rd(3'd3, d); chk("R10 set wins over clear", d, 32'd2);
    chk("R5 irq masked", irq, m[1]);
    wr(3'd3, 32'hF);
    wr(3'd0, 32'd3);
    chk_state("R6 waits one cycle", 3'd3);
    tick();
    chk_state("R6 to fifo ready", 3'd4);
    chk("R6 m2f_en high", m2f_en, 1);
    rd(3'd5, d); chk("R6 actual count", d, 32'd100 + tgt);
    rd(3'd0, d); chk("R6 request consumed", d, 32'd1);
    fifo_level = 8'd63;
    tick(3);
    chk_state("R7 below threshold holds", 3'd4);
    fifo_level = 8'd64;
    tick();
    fifo_level = 8'd0;
    chk_state("R7 to read data", 3'd5);
    rd(3'd1, d); chk("R7 data ready bit", d[3], 1);
    chk("R7 irq masked", irq, m[2]);
    wr(3'd3, 32'hF);
    if (early) begin
      m2f_done = 1'b1; tick(); m2f_done = 1'b0;
      tick(2);
      chk_state("R8 done without ack holds", 3'd5);
      wr(3'd0, 32'd5);
      tick();
    end else begin
      wr(3'd0, 32'd5);
      tick(2);
      chk_state("R8 ack without done holds", 3'd5);
      m2f_done = 1'b1; tick(); m2f_done = 1'b0;
    end
    chk_state("R8 to complete", 3'd6);
    chk("R8 m2f_en drops", m2f_en, 0);
    for (int i = 0; i < tgt; i++) begin
      chk_state("R9 waits for fetches", 3'd6);
      host_pop = 1'b1; tick(); host_pop = 1'b0;
    end
    tick();
    chk_state("R9 back to idle", 3'd0);
    chk("R9 irq masked", irq, m[3]);
    rd(3'd3, d); chk("R9 cause bit 3", d[3], 1);
    rd(3'd1, d); chk("R9 data ready cleared", d[3], 0);
    wr(3'd3, 32'hF);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick(3);
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 register reset", d, 0);
    end
    chk("R1 irq low", irq, 0);
    chk("R1 cap_en low", cap_en, 0);
    chk("R1 m2f_en low", m2f_en, 0);
    rst_n = 1'b1;
    tick();
    // R2 sweep of incomplete start conditions
    for (int c = 0; c < 7; c++) begin
      mem_init_done = c[0];
      wr(3'd0, {31'd0, c[1]});
      hard_cap = c[2];
      tick(4);
      hard_cap = 1'b0;
      tick(2);
      chk_state("R2 stays idle", 3'd0);
      chk("R2 cap_en low in idle", cap_en, 0);
    end
    mem_init_done = 1'b1;
    run_flow(0, 1'b1, 4'h0, 1'b0);
    run_flow(1, 1'b0, 4'hF, 1'b1);
    run_flow(5, 1'b1, 4'hA, 1'b1);
    run_flow(9, 1'b0, 4'h5, 1'b0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule